// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Single-Move Transfer Channels

This block collects event pulses from up to 28 peripheral sources and decides which one the CPU should serve next. Each source has a request flag and a control register with a 4-bit level, a 2-bit group value, an enable bit and an optional routing to one of 8 transfer channels. The winning pending source is the one with the highest level, then the highest group, then the lowest index. It is only accepted while interrupts are globally enabled and its level is strictly above the level the CPU is running at.

An accepted source is served in one of two ways. If it is routed to a channel whose transfer count is nonzero, the block raises a move request that carries the channel's source and destination addresses. When the memory side acknowledges, the flag clears and the count drops by one. No vector is produced in that case, so the CPU loses only the single slot the move takes. Otherwise the block presents a vector, computed as a base plus four times the source index, together with the source level, and holds both until the CPU acknowledges.

Top module: `evtic_top`

## Requirements
- R1: After a synchronous active-low reset, all request flags, source controls and channel registers are zero, and `irq_req` and `mv_req` are low.
- R2: An `evt_i` pulse sets the source flag, which stays set until serviced. A control write (address = source index) loads the flag from data bit 14, so software can set or clear it. A write wins over an event in the same cycle.
- R3: A source competes only if its enable bit (data bit 6) is set. It is accepted only while `cpu_ien` is high and its level (bits 3:0) is strictly greater than `cpu_lvl`.
- R4: Among competing sources, the higher level wins.
- R5: At equal level, the higher group value (bits 5:4) wins.
- R6: At equal level and group, the lower source index wins.
- R7: While `irq_req` is high, `irq_vec` = VEC_BASE + 4 × index and `irq_lvl` = the source level. Both stay stable until `irq_ack`, even if a stronger request arrives.
- R8: `irq_ack` clears the served flag and ends the request. The next winner is presented one cycle later.
- R9: If the route bit (bit 7) is set and the channel count for the channel in bits 10:8 is nonzero, the block raises `mv_req` instead, with `mv_src`/`mv_dst` taken from that channel. Channel c has its source at 0x40+4c, its destination at 0x41+4c and its count at 0x42+4c.
- R10: `mv_ack` clears the served flag and decrements the channel count by one.
- R11: A routed source whose channel count is zero is served by the vectored path.
- R12: `irq_req` and `mv_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NSRC | Per-source event pulses |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | REG_AW | Register write address |
| cfg_wdata | input | REG_DW | Register write data |
| cpu_lvl | input | 4 | Current CPU priority level |
| cpu_ien | input | 1 | Global interrupt enable |
| irq_req | output | 1 | Vectored interrupt request |
| irq_vec | output | VEC_W | Vector of the presented source |
| irq_lvl | output | 4 | Level of the accepted source |
| irq_ack | input | 1 | CPU acknowledge of the vector |
| mv_req | output | 1 | Single-move request |
| mv_src | output | AW | Move source address |
| mv_dst | output | AW | Move destination address |
| mv_ack | input | 1 | Move completion |

## Verification
The hardest situation to reach is a channel running its count down to zero, so that the same source switches from moves to vectored service partway through a sequence. The bench programs a channel with count two and fires the same source three times. It expects two moves and then a vector. Tie-breaking is reached by holding `cpu_ien` low while software-set flags load two sources at once, then enabling. This makes both sources compete in the same cycle, and the bench sweeps every level pair and every group pair.

// File: rtl/evtic_pkg.sv
// Package: shared types and field widths of the interrupt controller.
package evtic_pkg;
    localparam int LVL_W = 4;
    localparam int GRP_W = 2;
    localparam int CH_W  = 3;
    localparam int KEY_W = LVL_W + GRP_W;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [GRP_W-1:0] grp;
        logic             en;
        logic             route;
        logic [CH_W-1:0]  chan;
    } src_cfg_t;

    typedef enum logic [1:0] {ST_IDLE, ST_VEC, ST_MOVE} svc_st_t;
endpackage

// File: rtl/evtic_src_bank.sv
// Per-source request flags and control registers.
// Assumes source i sits at register address i. Data layout: [3:0] level,
// [5:4] group, [6] enable, [7] route, [10:8] channel, [14] flag value.
// Priority on the flag: software write, then event, then service clear.
module evtic_src_bank
    import evtic_pkg::*;
#(
    parameter int NSRC   = 28,
    parameter int REG_AW = 8,
    parameter int REG_DW = 16,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSRC-1:0]          evt_i,
    input  logic                     wr_en,
    input  logic [REG_AW-1:0]        wr_addr,
    input  logic [REG_DW-1:0]        wr_data,
    input  logic                     clr_en,
    input  logic [IDX_W-1:0]         clr_idx,
    output src_cfg_t [NSRC-1:0]      cfg_o,
    output logic [NSRC-1:0]          pend_o
);
    logic unused_bits;
    assign unused_bits = ^{wr_data[REG_DW-1:15], wr_data[13:11]};

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        src_cfg_t cfg_q;
        logic     flag_q;
        logic     hit;

        assign hit = wr_en && (wr_addr == REG_AW'(i));

        // Load control fields and update the request flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q  <= '0;
                flag_q <= 1'b0;
            end else if (hit) begin
                cfg_q  <= '{lvl: wr_data[3:0], grp: wr_data[5:4], en: wr_data[6],
                            route: wr_data[7], chan: wr_data[10:8]};
                flag_q <= wr_data[14];
            end else if (evt_i[i]) begin
                flag_q <= 1'b1;
            end else if (clr_en && clr_idx == IDX_W'(i)) begin
                flag_q <= 1'b0;
            end
        end

        assign cfg_o[i]  = cfg_q;
        assign pend_o[i] = flag_q && cfg_q.en;

        // R2: an event without a competing write always leaves the flag set.
        p_evt_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_i[i] && !hit) |=> flag_q);
    end
endmodule

// File: rtl/evtic_pick.sv
// Combinational winner selection among pending sources.
// Key = {level, group}; a strictly larger key replaces the current best,
// so among equal keys the lowest index is kept.
module evtic_pick
    import evtic_pkg::*;
#(
    parameter int NSRC   = 28,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]             pend_i,
    input  logic [NSRC-1:0][KEY_W-1:0]  key_i,
    output logic                        win_vld,
    output logic [IDX_W-1:0]            win_idx,
    output logic [LVL_W-1:0]            win_lvl
);
    logic [KEY_W-1:0] best;

    // Linear scan for the highest key, lowest index on ties.
    always_comb begin
        win_vld = 1'b0;
        win_idx = '0;
        best    = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend_i[i] && (!win_vld || key_i[i] > best)) begin
                win_vld = 1'b1;
                win_idx = IDX_W'(i);
                best    = key_i[i];
            end
        end
        win_lvl = best[KEY_W-1:GRP_W];
    end
endmodule

// File: rtl/evtic_chan_bank.sv
// Transfer channel registers: source address, destination address, count.
// Channel c occupies CH_BASE+4c (source), +1 (destination), +2 (count).
// The count decrements by one on each completed move; a write wins.
module evtic_chan_bank
    import evtic_pkg::*;
#(
    parameter int REG_AW  = 8,
    parameter int REG_DW  = 16,
    parameter int AW      = 16,
    parameter int CNT_W   = 8,
    parameter int CH_BASE = 'h40,
    localparam int NCH    = 1 << CH_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [REG_AW-1:0]              wr_addr,
    input  logic [REG_DW-1:0]              wr_data,
    input  logic                           dec_en,
    input  logic [CH_W-1:0]                dec_ch,
    output logic [NCH-1:0][AW-1:0]         src_o,
    output logic [NCH-1:0][AW-1:0]         dst_o,
    output logic [NCH-1:0][CNT_W-1:0]      cnt_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [AW-1:0]    src_q, dst_q;
        logic [CNT_W-1:0] cnt_q;
        logic             hit_s, hit_d, hit_c, dec_me;

        assign hit_s  = wr_en && (wr_addr == REG_AW'(CH_BASE + 4*c));
        assign hit_d  = wr_en && (wr_addr == REG_AW'(CH_BASE + 4*c + 1));
        assign hit_c  = wr_en && (wr_addr == REG_AW'(CH_BASE + 4*c + 2));
        assign dec_me = dec_en && (dec_ch == CH_W'(c));

        // Address registers written by software only.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_q <= '0;
                dst_q <= '0;
            end else begin
                if (hit_s) src_q <= wr_data[AW-1:0];
                if (hit_d) dst_q <= wr_data[AW-1:0];
            end
        end

        // Transfer count: software load, hardware decrement.
        always_ff @(posedge clk) begin
            if (!rst_n)                     cnt_q <= '0;
            else if (hit_c)                 cnt_q <= wr_data[CNT_W-1:0];
            else if (dec_me && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end

        assign src_o[c] = src_q;
        assign dst_o[c] = dst_q;
        assign cnt_o[c] = cnt_q;

        // R10: a completed move takes exactly one off a nonzero count.
        p_cnt_dec_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_me && !hit_c && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
    end
endmodule

// File: rtl/evtic_top.sv
// Interrupt controller top: arbitration, acceptance against the CPU level,
// and the service sequencer choosing vectored or single-move service.
// Assumes irq_ack / mv_ack are only asserted while the matching request
// is high; one request is in service at a time.
module evtic_top
    import evtic_pkg::*;
#(
    parameter int NSRC     = 28,
    parameter int REG_AW   = 8,
    parameter int REG_DW   = 16,
    parameter int AW       = 16,
    parameter int CNT_W    = 8,
    parameter int VEC_W    = 16,
    parameter int VEC_BASE = 'h40,
    localparam int IDX_W   = $clog2(NSRC),
    localparam int NCH     = 1 << CH_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC-1:0]      evt_i,
    input  logic                 cfg_we,
    input  logic [REG_AW-1:0]    cfg_addr,
    input  logic [REG_DW-1:0]    cfg_wdata,
    input  logic [LVL_W-1:0]     cpu_lvl,
    input  logic                 cpu_ien,
    output logic                 irq_req,
    output logic [VEC_W-1:0]     irq_vec,
    output logic [LVL_W-1:0]     irq_lvl,
    input  logic                 irq_ack,
    output logic                 mv_req,
    output logic [AW-1:0]        mv_src,
    output logic [AW-1:0]        mv_dst,
    input  logic                 mv_ack
);
    src_cfg_t [NSRC-1:0]         cfg_w;
    logic [NSRC-1:0]             pend_w;
    logic [NSRC-1:0][KEY_W-1:0]  key_w;
    logic [NCH-1:0][AW-1:0]      csrc_w, cdst_w;
    logic [NCH-1:0][CNT_W-1:0]   ccnt_w;
    logic                        win_vld, accept, use_move, clr_en, dec_en;
    logic [IDX_W-1:0]            win_idx;
    logic [LVL_W-1:0]            win_lvl;
    src_cfg_t                    win_cfg;

    svc_st_t          st_q;
    logic [IDX_W-1:0] cur_idx_q;
    logic [LVL_W-1:0] cur_lvl_q;
    logic [CH_W-1:0]  cur_ch_q;

    evtic_src_bank #(.NSRC(NSRC), .REG_AW(REG_AW), .REG_DW(REG_DW)) u_src (
        .clk, .rst_n, .evt_i,
        .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
        .clr_en, .clr_idx(cur_idx_q), .cfg_o(cfg_w), .pend_o(pend_w)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_key
        assign key_w[i] = {cfg_w[i].lvl, cfg_w[i].grp};
    end

    evtic_pick #(.NSRC(NSRC)) u_pick (
        .pend_i(pend_w), .key_i(key_w),
        .win_vld, .win_idx, .win_lvl
    );

    evtic_chan_bank #(.REG_AW(REG_AW), .REG_DW(REG_DW), .AW(AW), .CNT_W(CNT_W)) u_chan (
        .clk, .rst_n,
        .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
        .dec_en, .dec_ch(cur_ch_q),
        .src_o(csrc_w), .dst_o(cdst_w), .cnt_o(ccnt_w)
    );

    // Acceptance and service-path choice for the current winner.
    always_comb begin
        win_cfg  = cfg_w[win_idx];
        accept   = win_vld && cpu_ien && (win_lvl > cpu_lvl);
        use_move = win_cfg.route && (ccnt_w[win_cfg.chan] != '0);
        clr_en   = (st_q == ST_VEC && irq_ack) || (st_q == ST_MOVE && mv_ack);
        dec_en   = (st_q == ST_MOVE && mv_ack);
    end

    // Service sequencer: latch the accepted source and wait for its acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            cur_idx_q <= '0;
            cur_lvl_q <= '0;
            cur_ch_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (accept) begin
                    cur_idx_q <= win_idx;
                    cur_lvl_q <= win_lvl;
                    cur_ch_q  <= win_cfg.chan;
                    st_q      <= use_move ? ST_MOVE : ST_VEC;
                end
                ST_VEC:  if (irq_ack) st_q <= ST_IDLE;
                ST_MOVE: if (mv_ack)  st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign irq_req = (st_q == ST_VEC);
    assign mv_req  = (st_q == ST_MOVE);
    assign irq_vec = VEC_W'(VEC_BASE) + VEC_W'({cur_idx_q, 2'b00});
    assign irq_lvl = cur_lvl_q;
    assign mv_src  = csrc_w[cur_ch_q];
    assign mv_dst  = cdst_w[cur_ch_q];

    // R7: a presented vector holds until acknowledged.
    p_vec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec) && $stable(irq_lvl)));

    // R12: the two service paths never overlap.
    p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_req && mv_req));

    // R3: any new service starts only above the CPU level with enable set.
    p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_req) || $rose(mv_req)) |-> ($past(cpu_ien) && irq_lvl > $past(cpu_lvl)));

    // R10: a move request ends right after its acknowledge.
    p_move_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_req && mv_ack) |=> !mv_req);
endmodule

// File: tb/test_evtic_top.sv
`timescale 1ns/1ps
module test_evtic_top;
    localparam int NSRC = 28;
    localparam int VB   = 'h40;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] evt_i = '0;
    logic            cfg_we = 1'b0;
    logic [7:0]      cfg_addr = '0;
    logic [15:0]     cfg_wdata = '0;
    logic [3:0]      cpu_lvl = '0;
    logic            cpu_ien = 1'b0;
    logic            irq_req, mv_req;
    logic [15:0]     irq_vec, mv_src, mv_dst;
    logic [3:0]      irq_lvl;
    logic            irq_ack = 1'b0, mv_ack = 1'b0;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    evtic_top i_evtic_top (
        .clk, .rst_n, .evt_i, .cfg_we, .cfg_addr, .cfg_wdata,
        .cpu_lvl, .cpu_ien, .irq_req, .irq_vec, .irq_lvl, .irq_ack,
        .mv_req, .mv_src, .mv_dst, .mv_ack
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] cw(int lvl, int grp, bit en, bit route, int ch, bit flag);
        return 16'((lvl & 15) | ((grp & 3) << 4) | (int'(en) << 6) | (int'(route) << 7)
                   | ((ch & 7) << 8) | (int'(flag) << 14));
    endfunction

    task automatic wr(int addr, logic [15:0] data);
        cfg_we = 1'b1; cfg_addr = 8'(addr); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic pulse(int s);
        evt_i[s] = 1'b1;
        @(negedge clk);
        evt_i[s] = 1'b0;
    endtask

    task automatic clr_all();
        cpu_ien = 1'b0;
        for (int s = 0; s < NSRC; s++) wr(s, 16'h0);
        @(negedge clk);
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, and nothing pending even when fully enabled.
        chk("R1 irq_req", irq_req, 0);
        chk("R1 mv_req", mv_req, 0);
        cpu_ien = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle after enable", irq_req | mv_req, 0);

        // R7/R8: every source through the event path, vector arithmetic.
        for (int s = 0; s < NSRC; s++) begin
            cpu_ien = 1'b1; cpu_lvl = 0;
            wr(s, cw(1 + s % 15, s % 4, 1, 0, 0, 0));
            pulse(s);
            @(negedge clk);
            chk("R7 req", irq_req, 1);
            chk("R7 vector", irq_vec, VB + 4 * s);
            chk("R7 level", irq_lvl, 1 + s % 15);
            ack();
            chk("R8 drop", irq_req, 0);
            @(negedge clk);
            chk("R8 flag cleared", irq_req, 0);
            wr(s, 16'h0);
        end

        // R3: level against CPU level sweep.
        for (int l = 0; l < 16; l++) begin
            for (int c = 0; c < 16; c++) begin
                cpu_ien = 1'b1; cpu_lvl = 4'(c);
                wr(5, cw(l, 0, 1, 0, 0, 1));
                @(negedge clk);
                chk("R3 strict level compare", irq_req, (l > c) ? 1 : 0);
                if (irq_req) ack();
                wr(5, 16'h0);
            end
        end
        cpu_lvl = 0;
        // R3: global enable low and source enable low block service.
        cpu_ien = 1'b0;
        wr(6, cw(15, 0, 1, 0, 0, 1));
        repeat (2) @(negedge clk);
        chk("R3 global enable off", irq_req, 0);
        cpu_ien = 1'b1;
        @(negedge clk);
        chk("R3 global enable on", irq_vec, VB + 24);
        ack();
        wr(6, cw(15, 0, 0, 0, 0, 1));
        repeat (2) @(negedge clk);
        chk("R3 source disabled", irq_req, 0);
        clr_all();

        // R2: software clear cancels a pending event; software set raises one.
        cpu_ien = 1'b0;
        wr(3, cw(9, 0, 1, 0, 0, 0));
        pulse(3);
        wr(3, cw(9, 0, 1, 0, 0, 0));
        cpu_ien = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 software clear", irq_req, 0);
        cpu_ien = 1'b0;
        pulse(3);
        repeat (3) @(negedge clk);
        cpu_ien = 1'b1;
        @(negedge clk);
        chk("R2 flag held", irq_vec, VB + 12);
        ack();
        wr(3, cw(9, 0, 1, 0, 0, 1));
        @(negedge clk);
        chk("R2 software set", irq_req, 1);
        ack();
        // R2: write wins over event in the same cycle.
        cpu_ien = 1'b0;
        evt_i[3] = 1'b1;
        wr(3, cw(9, 0, 1, 0, 0, 0));
        evt_i[3] = 1'b0;
        cpu_ien = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 write beats event", irq_req, 0);
        clr_all();

        // R4/R6: every level pair for sources 2 and 9, group 0.
        for (int la = 1; la < 16; la++) begin
            for (int lb = 1; lb < 16; lb++) begin
                int w, o;
                wr(2, cw(la, 0, 1, 0, 0, 1));
                wr(9, cw(lb, 0, 1, 0, 0, 1));
                cpu_ien = 1'b1;
                @(negedge clk);
                w = (lb > la) ? 9 : 2;
                o = (w == 9) ? 2 : 9;
                chk(la == lb ? "R6 index tie" : "R4 level wins", irq_vec, VB + 4 * w);
                ack();
                @(negedge clk);
                chk("R8 next winner", irq_vec, VB + 4 * o);
                ack();
                cpu_ien = 1'b0;
            end
        end
        // R5/R6: every group pair at equal level.
        for (int ga = 0; ga < 4; ga++) begin
            for (int gb = 0; gb < 4; gb++) begin
                int w;
                wr(11, cw(6, ga, 1, 0, 0, 1));
                wr(4, cw(6, gb, 1, 0, 0, 1));
                cpu_ien = 1'b1;
                @(negedge clk);
                w = (ga > gb) ? 11 : 4;
                chk(ga == gb ? "R6 index tie" : "R5 group wins", irq_vec, VB + 4 * w);
                ack();
                @(negedge clk);
                ack();
                cpu_ien = 1'b0;
            end
        end
        clr_all();

        // R7: vector held while a stronger request arrives.
        cpu_ien = 1'b1;
        wr(1, cw(15, 0, 1, 0, 0, 0));
        wr(20, cw(5, 0, 1, 0, 0, 1));
        @(negedge clk);
        chk("R7 first vector", irq_vec, VB + 80);
        pulse(1);
        repeat (3) @(negedge clk);
        chk("R7 held vector", irq_vec, VB + 80);
        chk("R7 held level", irq_lvl, 5);
        ack();
        @(negedge clk);
        chk("R8 stronger next", irq_vec, VB + 4);
        ack();
        clr_all();

        // R9/R10/R11: channel 2, count 2, source 7 routed.
        wr('h48, 16'h1234);
        wr('h49, 16'hABCD);
        wr('h4A, 16'd2);
        cpu_ien = 1'b1;
        wr(7, cw(4, 0, 1, 1, 2, 0));
        for (int k = 0; k < 2; k++) begin
            pulse(7);
            @(negedge clk);
            chk("R9 move request", mv_req, 1);
            chk("R9 no vector", irq_req, 0);
            chk("R9 source addr", mv_src, 16'h1234);
            chk("R9 dest addr", mv_dst, 16'hABCD);
            mv_ack = 1'b1;
            @(negedge clk);
            mv_ack = 1'b0;
            chk("R10 move done", mv_req, 0);
            @(negedge clk);
            chk("R10 flag cleared", mv_req | irq_req, 0);
        end
        pulse(7);
        @(negedge clk);
        chk("R11 count exhausted", irq_req, 1);
        chk("R11 no move", mv_req, 0);
        chk("R11 vector", irq_vec, VB + 28);
        ack();
        // R11: routed to a channel that was never loaded.
        wr(8, cw(4, 0, 1, 1, 5, 1));
        @(negedge clk);
        chk("R11 zero count channel", irq_vec, VB + 32);
        ack();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule